// File: doc/BRIEF.md
# Credit-Limited Stream Scheduler

Several producer streams share one outbound link. Each stream owns a small ring of message slots, and each message is a fixed number of words. A stream that holds a message, is not already waiting, and still has credit places its index in a shared pointer queue. The queue never holds more than one entry per stream. A single sender takes indices from the queue in arrival order. For each index it copies that stream's oldest message to the link, one word per cycle in which the link FIFO reports a free slot.

Backpressure works through credits rather than through ring occupancy alone. Each stream counts the messages it has committed to the link that the far end has not yet acknowledged. The counter rises when the stream's pointer enters the queue and falls on each returned dequeue acknowledge. When the count reaches the number of slots in the stream's ring, the producer of that stream is refused. It is served again once acknowledges return.

Top module: `scs_top`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low, every `cred_err` bit is low, and every `prod_ready` bit is high.
- R2: A message leaves as MSG_WORDS consecutive words on `out_data`, with bits [WORD_W-1:0] of `prod_msg` first. `out_stream` names the source stream for all words of the message, and `out_last` is high only on the final word.
- R3: While `out_valid` is high and `out_ready` is low, `out_data`, `out_stream` and `out_valid` hold their values.
- R4: Streams are served in the order their pointers entered the queue. When several streams become eligible in the same cycle, the lowest index enters first.
- R5: A stream has at most one pointer queued or in service. A stream holding several messages is queued again after each one completes, and its messages leave in the order they were written.
- R6: A stream's outstanding count rises by one when its pointer enters the queue and falls by one on `ack_valid` for that stream. `prod_ready` for the stream is low whenever the count equals SLOTS, and a stream at that count is not queued.
- R7: `prod_ready` for a stream is also low when its ring holds SLOTS messages. A write presented while `prod_ready` for the addressed stream is low is ignored and never appears on the output.
- R8: A queue entry and an acknowledge for the same stream in the same cycle leave its count unchanged.
- R9: An acknowledge for a stream whose count is zero leaves the count at zero and sets that stream's `cred_err` bit. The bit stays set until reset.
- R10: Once an acknowledge brings a stream below its limit, its producer is accepted again and its next message is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | Producer write strobe |
| prod_stream | input | $clog2(N_STREAM) | Stream addressed by the write |
| prod_msg | input | MSG_WORDS*WORD_W | Whole message, word 0 in the low bits |
| prod_ready | output | N_STREAM | Per-stream write acceptance |
| ack_valid | input | 1 | Dequeue acknowledge returned from the far end |
| ack_stream | input | $clog2(N_STREAM) | Stream the acknowledge belongs to |
| out_ready | input | 1 | Link FIFO has a free slot this cycle |
| out_valid | output | 1 | A word is presented |
| out_data | output | WORD_W | Presented word |
| out_stream | output | $clog2(N_STREAM) | Source stream of the word |
| out_last | output | 1 | Final word of the message |
| cred_err | output | N_STREAM | Sticky acknowledge-underflow flag per stream |

## Verification
A credit counter that drifts shows up directly on `prod_ready`. If the counter is too low, the stream accepts more messages than SLOTS before the ready drops. If it is too high, the stream stalls early. Either case is visible after the first handful of messages without acknowledges. A lost or duplicated queue entry shows up on the next message as an out-of-order `out_stream` sequence or as a message that never leaves. A wrong ring pointer returns a stale message on the following delivery. A word-index error corrupts `out_data` or misplaces `out_last` inside the message in which it happens.

// File: rtl/scs_pkg.sv
package scs_pkg;
    typedef enum logic {
        SND_IDLE = 1'b0,
        SND_COPY = 1'b1
    } snd_state_e;
endpackage

// File: rtl/scs_credit.sv
// Outstanding-message counter for one stream.
module scs_credit #(
    parameter  int SLOTS = 4,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          at_limit,
    output logic          underflow
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          uf;
    } cred_t;

    cred_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (inc && !dec) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end else if (dec && !inc) begin
            if (c_q.cnt == '0) c_d.uf  = 1'b1;
            else               c_d.cnt = c_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt       = c_q.cnt;
    assign at_limit  = (c_q.cnt == CW'(SLOTS));
    assign underflow = c_q.uf;
endmodule

// File: rtl/scs_ptr_queue.sv
// FIFO of stream indices; the caller guarantees it never overfills.
module scs_ptr_queue #(
    parameter  int DEPTH = 4,
    parameter  int IW    = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [IW-1:0] head_idx,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][IW-1:0] slot;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } pq_t;

    pq_t q_d, q_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.slot[q_q.wr] = push_idx;
            q_d.wr           = step(q_q.wr);
        end
        if (pop) q_d.rd = step(q_q.rd);
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_idx = q_q.slot[q_q.rd];
    assign empty    = (q_q.cnt == '0);
endmodule

// File: rtl/scs_top.sv
// Per-stream message rings, one-entry-per-stream pointer queue,
// word-serial sender and per-stream credit counters.
module scs_top #(
    parameter  int N_STREAM  = 4,
    parameter  int SLOTS     = 4,
    parameter  int MSG_WORDS = 2,
    parameter  int WORD_W    = 8,
    localparam int SW        = (N_STREAM > 1) ? $clog2(N_STREAM) : 1,
    localparam int MSG_W     = MSG_WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prod_valid,
    input  logic [SW-1:0]       prod_stream,
    input  logic [MSG_W-1:0]    prod_msg,
    output logic [N_STREAM-1:0] prod_ready,
    input  logic                ack_valid,
    input  logic [SW-1:0]       ack_stream,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    output logic [SW-1:0]       out_stream,
    output logic                out_last,
    output logic [N_STREAM-1:0] cred_err
);
    import scs_pkg::*;

    localparam int PW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int OW  = $clog2(SLOTS + 1);
    localparam int CW  = $clog2(SLOTS + 1);
    localparam int WIX = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;

    typedef struct packed {
        logic [N_STREAM-1:0][SLOTS-1:0][MSG_W-1:0] mem;
        logic [N_STREAM-1:0][PW-1:0]               wr;
        logic [N_STREAM-1:0][PW-1:0]               rd;
        logic [N_STREAM-1:0][OW-1:0]               occ;
        logic [N_STREAM-1:0]                       queued;
        snd_state_e                                st;
        logic [SW-1:0]                             cur;
        logic [WIX-1:0]                            wix;
    } state_t;

    state_t s_d, s_q;

    logic [N_STREAM-1:0]    at_limit;
    logic [N_STREAM-1:0]    cred_inc;
    logic [N_STREAM-1:0]    cred_dec;
    logic [N_STREAM*CW-1:0] cnt_flat;
    logic [N_STREAM-1:0]    wr_en;
    logic [N_STREAM-1:0]    rd_en;
    logic [N_STREAM-1:0]    elig;
    logic                   q_push;
    logic [SW-1:0]          q_idx;
    logic                   q_pop;
    logic [SW-1:0]          q_head;
    logic                   q_empty;

    function automatic logic [PW-1:0] ring_step(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Producer acceptance and queue eligibility from registered state.
    always_comb begin
        for (int i = 0; i < N_STREAM; i++) begin
            prod_ready[i] = (s_q.occ[i] != OW'(SLOTS)) && !at_limit[i];
            elig[i]       = (s_q.occ[i] != '0) && !s_q.queued[i] && !at_limit[i];
            wr_en[i]      = prod_valid && prod_ready[i] && (prod_stream == SW'(i));
        end
    end

    always_comb begin
        s_d      = s_q;
        q_push   = 1'b0;
        q_idx    = '0;
        q_pop    = 1'b0;
        cred_inc = '0;
        rd_en    = '0;

        // Lowest eligible index enters the queue this cycle.
        for (int i = N_STREAM - 1; i >= 0; i--) begin
            if (elig[i]) begin
                q_push = 1'b1;
                q_idx  = SW'(i);
            end
        end
        if (q_push) begin
            s_d.queued[q_idx] = 1'b1;
            cred_inc[q_idx]   = 1'b1;
        end

        // Sender: take one index, then copy its message word by word.
        case (s_q.st)
            SND_IDLE: begin
                if (!q_empty) begin
                    q_pop   = 1'b1;
                    s_d.cur = q_head;
                    s_d.wix = '0;
                    s_d.st  = SND_COPY;
                end
            end
            SND_COPY: begin
                if (out_ready) begin
                    if (s_q.wix == WIX'(MSG_WORDS - 1)) begin
                        rd_en[s_q.cur]      = 1'b1;
                        s_d.queued[s_q.cur] = 1'b0;
                        s_d.st              = SND_IDLE;
                    end else begin
                        s_d.wix = s_q.wix + 1'b1;
                    end
                end
            end
            default: s_d.st = SND_IDLE;
        endcase

        // Ring storage and occupancy.
        for (int i = 0; i < N_STREAM; i++) begin
            if (wr_en[i]) begin
                s_d.mem[i][s_q.wr[i]] = prod_msg;
                s_d.wr[i]             = ring_step(s_q.wr[i]);
            end
            if (rd_en[i]) s_d.rd[i] = ring_step(s_q.rd[i]);
            s_d.occ[i] = s_q.occ[i] + OW'(wr_en[i]) - OW'(rd_en[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    scs_ptr_queue #(.DEPTH(N_STREAM), .IW(SW)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_idx (q_idx),
        .pop      (q_pop),
        .head_idx (q_head),
        .empty    (q_empty)
    );

    for (genvar g = 0; g < N_STREAM; g++) begin : g_cred
        assign cred_dec[g] = ack_valid && (ack_stream == SW'(g));
        scs_credit #(.SLOTS(SLOTS)) u_cred (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (cred_inc[g]),
            .dec       (cred_dec[g]),
            .cnt       (cnt_flat[g*CW +: CW]),
            .at_limit  (at_limit[g]),
            .underflow (cred_err[g])
        );
    end

    assign out_valid  = (s_q.st == SND_COPY);
    assign out_stream = s_q.cur;
    assign out_data   = s_q.mem[s_q.cur][s_q.rd[s_q.cur]][int'(s_q.wix)*WORD_W +: WORD_W];
    assign out_last   = out_valid && (s_q.wix == WIX'(MSG_WORDS - 1));
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
    parameter  int N_STREAM = 4,
    parameter  int SLOTS    = 4,
    parameter  int WORD_W   = 8,
    localparam int SW       = (N_STREAM > 1) ? $clog2(N_STREAM) : 1,
    localparam int CW       = $clog2(SLOTS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [WORD_W-1:0]      out_data,
    input logic [SW-1:0]          out_stream,
    input logic                   out_last,
    input logic [N_STREAM-1:0]    prod_ready,
    input logic [N_STREAM-1:0]    cred_err,
    input logic [N_STREAM*CW-1:0] cnt_flat
);
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_stream)));

    assert_msg_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && $stable(out_stream)));

    assert_last_in_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_err != '0) |=> ((cred_err & $past(cred_err)) == $past(cred_err)));

    for (genvar g = 0; g < N_STREAM; g++) begin : g_chk
        assert_credit_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[g*CW +: CW] <= CW'(SLOTS));

        assert_ready_at_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[g*CW +: CW] == CW'(SLOTS)) |-> !prod_ready[g]);
    end
endmodule

bind scs_top scs_checker #(
    .N_STREAM (N_STREAM),
    .SLOTS    (SLOTS),
    .WORD_W   (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_stream (out_stream),
    .out_last   (out_last),
    .prod_ready (prod_ready),
    .cred_err   (cred_err),
    .cnt_flat   (cnt_flat)
);

// File: tb/sim_scs_top.sv
module sim_scs_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prod_valid = 1'b0;
    logic [1:0]  prod_stream = '0;
    logic [15:0] prod_msg = '0;
    logic [3:0]  prod_ready;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_stream = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [1:0]  out_stream;
    logic        out_last;
    logic [3:0]  cred_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scs_top u0 (
        .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_stream(prod_stream),
        .prod_msg(prod_msg), .prod_ready(prod_ready), .ack_valid(ack_valid),
        .ack_stream(ack_stream), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_stream(out_stream), .out_last(out_last),
        .cred_err(cred_err)
    );

    // {stream[19:16], message[15:0]}
    localparam logic [19:0] VEC [0:7] = '{
        20'h0_A501, 20'h1_5AF2, 20'h2_0F0F, 20'h3_C33C,
        20'h2_1234, 20'h0_FFFE, 20'h3_8001, 20'h1_7E81
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int s, input logic [15:0] m);
        @(posedge clk) #1;
        while (!prod_ready[s]) begin
            @(posedge clk) #1;
        end
        prod_valid = 1'b1; prod_stream = 2'(s); prod_msg = m;
        @(posedge clk) #1;
        prod_valid = 1'b0;
    endtask

    task automatic ack(input int s);
        @(posedge clk) #1;
        ack_valid = 1'b1; ack_stream = 2'(s);
        @(posedge clk) #1;
        ack_valid = 1'b0;
    endtask

    // Collects one message; word 0 is the low byte (R2).
    task automatic recv(output int s, output logic [15:0] m);
        for (int w = 0; w < 2; w++) begin
            do @(negedge clk); while (!(out_valid && out_ready));
            m[w*8 +: 8] = out_data;
            if (w == 0) s = int'(out_stream);
            else chk(int'(out_stream) == s, "R2 stream steady", int'(out_stream), s);
            chk(out_last == (w == 1), "R2 last flag", int'(out_last), int'(w == 1));
        end
    endtask

    task automatic expect_msg(input int s_exp, input logic [15:0] m_exp, input string req);
        int s; logic [15:0] m;
        recv(s, m);
        chk(s == s_exp, req, s, s_exp);
        chk(m == m_exp, req, int'(m), int'(m_exp));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int accepted;
        bit seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(cred_err == 4'h0, "R1 cred_err", int'(cred_err), 0);
        chk(prod_ready == 4'hF, "R1 prod_ready", int'(prod_ready), 15);

        // Table walk: R2 word order and stream tag, then acknowledge.
        for (int k = 0; k < 8; k++) begin
            push(int'(VEC[k][19:16]), VEC[k][15:0]);
            expect_msg(int'(VEC[k][19:16]), VEC[k][15:0], "R2 table message");
            ack(int'(VEC[k][19:16]));
        end

        // R4 service order follows queue entry; R3 stall holds the word.
        out_ready = 1'b0;
        push(2, 16'h2222);
        push(0, 16'h0A0A);
        push(1, 16'h1B1B);
        repeat (2) @(negedge clk);
        chk(out_valid && out_stream == 2'd2 && out_data == 8'h22, "R3 held word",
            int'(out_data), 'h22);
        repeat (3) @(negedge clk);
        chk(out_valid && out_stream == 2'd2 && out_data == 8'h22, "R3 still held",
            int'(out_data), 'h22);
        @(posedge clk) #1 out_ready = 1'b1;
        expect_msg(2, 16'h2222, "R4 first served");
        expect_msg(0, 16'h0A0A, "R4 second served");
        expect_msg(1, 16'h1B1B, "R4 third served");
        ack(2); ack(0); ack(1);

        // R7 ring full refusal, R5 per-stream order and requeue.
        out_ready = 1'b0;
        for (int k = 0; k < 4; k++) push(1, 16'h1100 + 16'(k));
        @(posedge clk) #1;
        chk(prod_ready[1] == 1'b0, "R7 ring full", int'(prod_ready[1]), 0);
        out_ready = 1'b1;
        for (int k = 0; k < 4; k++) expect_msg(1, 16'h1100 + 16'(k), "R5 stream order");
        @(posedge clk) #1;
        chk(prod_ready[1] == 1'b0, "R6 limit after four", int'(prod_ready[1]), 0);
        for (int k = 0; k < 4; k++) ack(1);

        // R6 credit limit on stream 3 without acknowledges.
        for (int k = 0; k < 4; k++) begin
            push(3, 16'h3300 + 16'(k));
            expect_msg(3, 16'h3300 + 16'(k), "R6 send before limit");
        end
        @(posedge clk) #1;
        chk(prod_ready[3] == 1'b0, "R6 producer refused", int'(prod_ready[3]), 0);
        // R7 write while refused is dropped.
        prod_valid = 1'b1; prod_stream = 2'd3; prod_msg = 16'hDEAD;
        @(posedge clk) #1 prod_valid = 1'b0;
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(!seen, "R7 refused write silent", int'(seen), 0);
        // R10 recovery after one acknowledge.
        ack(3);
        chk(prod_ready[3] == 1'b1, "R10 ready after ack", int'(prod_ready[3]), 1);
        push(3, 16'h3C3C);
        expect_msg(3, 16'h3C3C, "R10 delivered after ack");
        for (int k = 0; k < 4; k++) ack(3);

        // R8 enqueue and acknowledge in the same cycle on stream 0.
        push(0, 16'h0101);
        expect_msg(0, 16'h0101, "R8 first message");
        @(posedge clk) #1;
        prod_valid = 1'b1; prod_stream = 2'd0; prod_msg = 16'h0202;
        @(posedge clk) #1;
        prod_valid = 1'b0; ack_valid = 1'b1; ack_stream = 2'd0;
        @(posedge clk) #1;
        ack_valid = 1'b0;
        expect_msg(0, 16'h0202, "R8 second message");
        accepted = 0;
        @(posedge clk) #1;
        while (prod_ready[0] && accepted < 6) begin
            push(0, 16'h0300 + 16'(accepted));
            expect_msg(0, 16'h0300 + 16'(accepted), "R8 fill message");
            accepted++;
            @(posedge clk) #1;
        end
        chk(accepted == 3, "R8 count unchanged", accepted, 3);
        for (int k = 0; k < 4; k++) ack(0);

        // R9 acknowledge at zero.
        chk(cred_err == 4'h0, "R9 no error yet", int'(cred_err), 0);
        ack(1);
        chk(cred_err == 4'b0010, "R9 error flag", int'(cred_err), 2);
        for (int k = 0; k < 4; k++) begin
            push(1, 16'h1900 + 16'(k));
            expect_msg(1, 16'h1900 + 16'(k), "R9 count held at zero");
            @(posedge clk) #1;
            if (k == 2) chk(prod_ready[1] == 1'b1, "R9 room after three",
                            int'(prod_ready[1]), 1);
        end
        chk(prod_ready[1] == 1'b0, "R9 limit after four", int'(prod_ready[1]), 0);
        chk(cred_err == 4'b0010, "R9 flag sticky", int'(cred_err), 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule